// File: doc/BRIEF.md
# Phase-Error Mode Selector

This block decides which phase-detection path steers a fractional-N digital PLL. Once per reference cycle, marked by a one-cycle `ref_tick` strobe, it samples a signed two's-complement phase error. It takes the magnitude of that error and compares it against two programmable limits. A wide limit moves the loop from coarse counting to fine time digitizing. A narrow limit, of about one inverter delay, moves it into bang-bang detection under the gain state machine.

The block steps through four regimes in a fixed order, one step per sample at most:

- code 0: linear detector with an oscillator cycle counter;
- code 1: linear detector with a delay-line time digitizer;
- code 2: bang-bang detector with the gain state machine active;
- code 3: bang-bang detector on its own.

It leaves code 2 when the gain controller reports that the derivative gain has reached zero. A frequency-word reconfiguration strobe sends it back to code 0 from any regime.

The regime is presented in two forms: as a binary code, and as a one-hot select for the loop filter.

Top module: `phase_mode_sel`

## Requirements
- R1: After reset, `mode` is 0 and `gain_sel` is 4'b0001.
- R2: In mode 0, a sample whose error magnitude is strictly less than `thr_coarse` moves the block to mode 1 on the clock edge of that sample. An equal or larger magnitude keeps it in mode 0.
- R3: In mode 1, a sample whose magnitude is strictly less than `thr_fine` moves the block to mode 2. Otherwise it stays in mode 1.
- R4: In mode 2, a sample taken while `dgain_zero` is high moves the block to mode 3. Otherwise it stays in mode 2.
- R5: When `freq_reconf` is high on a clock edge, `mode` is 0 after that edge, from any mode and whatever the other inputs are.
- R6: Magnitude is the absolute value of `phase_err`, so positive and negative errors behave the same way. The most negative value counts as 2^(ERR_W-1).
- R7: The mode changes only on an edge where `ref_tick` or `freq_reconf` is high. A single sample advances the mode by at most one step, even if the error is below both limits.
- R8: Mode 3 is held on every sample until a reconfiguration. `dgain_zero` has no effect in modes 0 and 1.
- R9: `gain_sel` is one-hot: bit k is set exactly when `mode` equals k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle strobe, one per reference cycle, that qualifies a sample |
| phase_err | input | ERR_W | Signed two's-complement phase error |
| thr_coarse | input | ERR_W | Unsigned magnitude limit for leaving mode 0 |
| thr_fine | input | ERR_W | Unsigned magnitude limit for leaving mode 1 |
| dgain_zero | input | 1 | High when the derivative gain has been used up |
| freq_reconf | input | 1 | Frequency-word reconfiguration strobe |
| mode | output | 2 | Current regime code, 0 to 3 |
| gain_sel | output | 4 | One-hot regime select for the loop filter |

## Verification
The block's only state is the regime register, and it appears directly on `mode` and `gain_sel`. A wrong state therefore shows at the ports on the edge after the faulty sample.

The bench targets the cases a faulty transition would reveal:

- magnitudes exactly equal to a limit;
- negative errors, including the most negative code;
- a first sample that is already below both limits;
- `dgain_zero` arriving in the wrong regime or without a tick;
- a reconfiguration that coincides with a qualifying sample.

// File: rtl/phase_mode_sel.sv
module phase_mode_sel #(
  parameter int ERR_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_tick,
  input  logic signed [ERR_W-1:0] phase_err,
  input  logic        [ERR_W-1:0] thr_coarse,
  input  logic        [ERR_W-1:0] thr_fine,
  input  logic                    dgain_zero,
  input  logic                    freq_reconf,
  output logic        [1:0]       mode,
  output logic        [3:0]       gain_sel
);

  typedef enum logic [1:0] {
    M_COUNT = 2'd0,
    M_TDC   = 2'd1,
    M_BBFSM = 2'd2,
    M_BB    = 2'd3
  } regime_t;

  regime_t             cur, nxt;
  logic    [ERR_W-1:0] err_mag;

  assign err_mag = phase_err[ERR_W-1] ? ERR_W'(-phase_err) : ERR_W'(phase_err);

  always_comb begin
    nxt = cur;
    if (freq_reconf) begin
      nxt = M_COUNT;
    end else if (ref_tick) begin
      unique case (cur)
        M_COUNT: if (err_mag < thr_coarse) nxt = M_TDC;
        M_TDC:   if (err_mag < thr_fine)   nxt = M_BBFSM;
        M_BBFSM: if (dgain_zero)           nxt = M_BB;
        M_BB:    nxt = M_BB;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= M_COUNT;
    else        cur <= nxt;
  end

  assign mode     = cur;
  assign gain_sel = 4'b0001 << cur;

endmodule

// File: rtl/phase_mode_sel_chk.sv
module phase_mode_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ref_tick,
  input logic       dgain_zero,
  input logic       freq_reconf,
  input logic [1:0] mode,
  input logic [3:0] gain_sel
);

  assert_onehot_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gain_sel) == 1 && gain_sel[mode]);

  assert_reconf_home_R5: assert property (@(posedge clk) disable iff (!rst_n)
    freq_reconf |=> mode == 2'd0);

  assert_hold_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_tick && !freq_reconf) |=> $stable(mode));

  assert_single_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !freq_reconf |=> (mode == $past(mode) || mode == $past(mode) + 2'd1));

  assert_fsm_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !dgain_zero && !freq_reconf) |=> mode == 2'd2);

  assert_terminal_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd3 && !freq_reconf) |=> mode == 2'd3);

endmodule

bind phase_mode_sel phase_mode_sel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .dgain_zero(dgain_zero),
  .freq_reconf(freq_reconf), .mode(mode), .gain_sel(gain_sel)
);

// File: tb/phase_mode_sel_tb.sv
module phase_mode_sel_tb_top;
  localparam int W = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                ref_tick = 1'b0;
  logic signed [W-1:0] phase_err = '0;
  logic        [W-1:0] thr_coarse = '0;
  logic        [W-1:0] thr_fine = '0;
  logic                dgain_zero = 1'b0;
  logic                freq_reconf = 1'b0;
  logic        [1:0]   mode;
  logic        [3:0]   gain_sel;

  int    checks = 0;
  int    errors = 0;
  int    model  = 0;
  bit    done   = 0;
  int    exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  phase_mode_sel #(.ERR_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .phase_err(phase_err),
    .thr_coarse(thr_coarse), .thr_fine(thr_fine), .dgain_zero(dgain_zero),
    .freq_reconf(freq_reconf), .mode(mode), .gain_sel(gain_sel)
  );

  task automatic compare(input int exp, input string tag);
    checks++;
    if (int'(mode) != exp || gain_sel != (4'b0001 << exp)) begin
      errors++;
      $display("FAIL %s: mode=%0d gain_sel=%b expected mode=%0d gain_sel=%b",
               tag, mode, gain_sel, exp, 4'b0001 << exp);
    end
  endtask

  task automatic step(input bit tick, input int err, input int t1, input int t2,
                      input bit dz, input bit rc, input string tag);
    int mag;
    @(negedge clk);
    ref_tick = tick; phase_err = W'(err); thr_coarse = W'(t1); thr_fine = W'(t2);
    dgain_zero = dz; freq_reconf = rc;
    mag = (err < 0) ? -err : err;
    if (rc) model = 0;
    else if (tick) begin
      case (model)
        0: if (mag < t1) model = 1;
        1: if (mag < t2) model = 2;
        2: if (dz) model = 3;
        default: model = 3;
      endcase
    end
    exp_q.push_back(model);
    tag_q.push_back(tag);
  endtask

  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    #12;
    compare(0, "R1 reset state");
    rst_n = 1'b1;
    step(1, 500, 100, 10, 0, 0, "R2 large error stays in mode 0");
    step(1, 300, 100, 10, 1, 0, "R8 dgain_zero ignored in mode 0");
    step(1, 100, 100, 10, 0, 0, "R2 equal to coarse limit stays");
    step(1, -99, 100, 10, 0, 0, "R2 R6 negative error below coarse limit");
    step(0, 0, 100, 10, 0, 0, "R7 no tick holds mode");
    step(1, 50, 100, 10, 1, 0, "R8 dgain_zero ignored in mode 1");
    step(1, 10, 100, 10, 0, 0, "R3 equal to fine limit stays");
    step(1, 9, 100, 10, 0, 0, "R3 below fine limit enters mode 2");
    step(1, 0, 100, 10, 0, 0, "R4 no done flag holds mode 2");
    step(0, 0, 100, 10, 1, 0, "R7 done flag without tick holds");
    step(1, 0, 100, 10, 1, 0, "R4 done flag on tick enters mode 3");
    step(1, 3000, 100, 10, 0, 0, "R8 mode 3 holds on large error");
    step(1, 0, 100, 10, 0, 0, "R8 mode 3 holds on small error");
    step(0, 0, 100, 10, 0, 1, "R5 reconfig returns to mode 0");
    step(1, 0, 100, 10, 1, 1, "R5 reconfig wins over tick");
    step(1, 0, 100, 10, 0, 0, "R7 one step only per sample");
    step(1, -10, 100, 10, 0, 0, "R6 negative equal to fine limit stays");
    step(1, -9, 100, 10, 0, 0, "R6 negative below fine limit");
    step(0, 0, 100, 10, 0, 1, "R5 reconfig from mode 2");
    step(1, -32768, 32768, 10, 0, 0, "R6 most negative equals 2^15 stays");
    step(1, -32768, 65535, 10, 0, 0, "R6 most negative below 65535 advances");
    step(1, 32767, 65535, 0, 0, 0, "R3 zero fine limit never passes");
    step(1, 0, 65535, 1, 0, 0, "R3 zero error below fine limit 1");
    step(1, 0, 0, 0, 1, 1, "R5 reconfig from mode 2 with done flag");
    step(0, 0, 0, 0, 0, 0, "R7 idle after reconfig");
    @(negedge clk); ref_tick = 0; freq_reconf = 0;
    repeat (3) @(posedge clk);
    #3;
    finish_run();
  end
endmodule